// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software through a free-running count of slow ticks. The count comes from a 1 kHz enable pulse that is synchronous to the system clock. Software must issue a restart before the selected timeout period runs out. If it does not, the block raises a one-clock system reset request.

Window mode adds a closed interval at the start of every period. A restart issued inside that interval counts as a fault and also raises the reset request. A restart in the following open interval clears the count and starts a new closed interval.

Two 8-bit registers hold the configuration: a control register and a window register. A write changes a register only when the protection-unlock input is high and bit 0 of the written data is one in that same write. Fuse inputs supply the reset values of the period and enable fields. A fuse lock input freezes the period fields while leaving the low two bits writable.

Top module: `win_wdog`

## Requirements
- R1: During and after reset the control register reads {2'b00, fuse_per_i, fuse_en_i, 1'b0} and the window register reads {2'b00, fuse_wper_i, fuse_wen_i, 1'b0}.
- R2: With a period code c in 0..10 in control bits [5:2] and no restart, the reset request appears on tick number 2^(c+3) counted from a cleared counter. The counter then restarts from zero, so the next request follows another 2^(c+3) ticks.
- R3: Period codes 11..15 in control bits [5:2] never produce a reset request, whatever the ticks or restarts.
- R4: A write whose data bit 0 is zero, or that occurs while unlock_i is low, leaves the addressed register unchanged.
- R5: Address 0 selects the control register: [5:2] period code, [1] enable, [0] change-enable. Address 1 selects the window register: [5:2] closed-window code, [1] window enable, [0] window change-enable. Bits [7:6] of both registers always read zero.
- R6: While fuse_lock_i is high, an accepted write updates only bits [1:0] of the addressed register, and bits [5:2] keep their value.
- R7: While the control enable bit is zero, the counter is held at zero and restarts and ticks never produce a request.
- R8: Outside window mode, a restart clears the counter, so a full period of ticks is needed again before a request.
- R9: In window mode, a restart before the closed window (2^(w+3) ticks, w = window code) has elapsed raises the request. The restart after exactly 2^(w+3)-1 ticks still faults. A new closed window then begins.
- R10: In window mode, a restart in the open window raises no request and starts a new closed window. Without a restart, the request comes after the closed-window ticks plus the period ticks.
- R11: A closed-window code of 11..15 makes window mode inactive, so early restarts raise no request and plain timeout behaviour applies.
- R12: reset_req_o is registered. It is high for exactly the clock after the edge that sampled the expiring tick or the faulting restart, and low in the clock that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse per 1 kHz oscillator cycle |
| restart_i | input | 1 | Watchdog restart command |
| unlock_i | input | 1 | Configuration-protection unlock |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write address: 0 control, 1 window |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read address: 0 control, 1 window |
| rd_data_o | output | 8 | Read data (combinational) |
| fuse_per_i | input | 4 | Reset value of the period code |
| fuse_en_i | input | 1 | Reset value of the enable bit |
| fuse_wper_i | input | 4 | Reset value of the closed-window code |
| fuse_wen_i | input | 1 | Reset value of the window enable bit |
| fuse_lock_i | input | 1 | Freezes bits [5:2] of both registers |
| reset_req_o | output | 1 | One-clock system reset request |

## Verification
Assertions check four properties on every cycle. A rejected or unauthorised write never alters a register, and a locked write never touches a period field. A disabled or reserved-period watchdog never requests a reset. A request always follows a tick or restart and leaves the counter at zero. The bench scenarios are needed for everything tied to exact tick counts. These include the full sweep of the eleven timeout periods, the off-by-one edge of the closed window, and the closed-plus-open timeout in window mode. The scenarios also cover register read-back after reset, reserved-bit masking, and inactive window mode under a reserved closed-window code.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CHG_BIT  = 0;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned FIELD_W  = CODE_LSB + CODE_W;
  localparam int unsigned NUM_REGS = 2;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_WIN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/wdt_per_dec.sv
module wdt_per_dec
  import wdt_pkg::*;
#(
  parameter int unsigned MAX_CODE   = 10,
  parameter int unsigned BASE_SHIFT = 3,
  parameter int unsigned CNT_W      = MAX_CODE + BASE_SHIFT + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cycles_o
);
  assign valid_o  = (int'(code_i) <= int'(MAX_CODE));
  assign cycles_o = valid_o ? (CNT_W'(1) << (int'(code_i) + int'(BASE_SHIFT))) : '0;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              unlock_i,
  input  logic              lock_i,
  input  logic [CODE_W-1:0] fuse_per_i,
  input  logic              fuse_en_i,
  input  logic [CODE_W-1:0] fuse_wper_i,
  input  logic              fuse_wen_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CODE_W-1:0] per_o,
  output logic              en_o,
  output logic [CODE_W-1:0] wper_o,
  output logic              wen_o
);
  logic [NUM_REGS-1:0][FIELD_W-1:0] regs_q;
  logic accept;
  logic unused_hi;

  // change-enable in the same write plus protection unlock
  assign accept    = wr_en_i && unlock_i && wr_data_i[CHG_BIT];
  assign unused_hi = ^wr_data_i[DATA_W-1:FIELD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q[REG_CTRL] <= {fuse_per_i, fuse_en_i, 1'b0};
      regs_q[REG_WIN]  <= {fuse_wper_i, fuse_wen_i, 1'b0};
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (accept && (wr_sel_i == 1'(i))) begin
          regs_q[i][EN_BIT:CHG_BIT] <= wr_data_i[EN_BIT:CHG_BIT];
          if (!lock_i) regs_q[i][FIELD_W-1:CODE_LSB] <= wr_data_i[FIELD_W-1:CODE_LSB];
        end
      end
    end
  end

  assign rd_data_o = DATA_W'(regs_q[rd_sel_i]);
  assign per_o     = regs_q[REG_CTRL][FIELD_W-1:CODE_LSB];
  assign en_o      = regs_q[REG_CTRL][EN_BIT];
  assign wper_o    = regs_q[REG_WIN][FIELD_W-1:CODE_LSB];
  assign wen_o     = regs_q[REG_WIN][EN_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    // R4
    rejected_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wr_sel_i == 1'(g)) && !(unlock_i && wr_data_i[CHG_BIT]))
        |=> $stable(regs_q[g]));
    // R6
    locked_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && lock_i) |=> $stable(regs_q[g][FIELD_W-1:CODE_LSB]));
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic             per_valid_i,
  input  logic [CNT_W-1:0] per_cycles_i,
  input  logic             win_en_i,
  input  logic             wper_valid_i,
  input  logic [CNT_W-1:0] wper_cycles_i,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             closed_q, closed_d;
  logic             req_q, req_d;
  logic             win_act, running;
  logic [CNT_W-1:0] plim, wlim;

  assign win_act = win_en_i && wper_valid_i;
  assign running = enable_i && per_valid_i;
  assign plim    = per_cycles_i - 1'b1;
  assign wlim    = wper_cycles_i - 1'b1;

  always_comb begin
    cnt_d    = cnt_q;
    closed_d = closed_q;
    req_d    = 1'b0;
    if (!running) begin
      cnt_d    = '0;
      closed_d = 1'b1;
    end else if (restart_i) begin
      cnt_d    = '0;
      closed_d = win_act;
      req_d    = win_act && closed_q;
    end else if (tick_i) begin
      if (win_act && closed_q) begin
        // >= keeps mid-count config changes from wrapping
        if (cnt_q >= wlim) begin
          cnt_d    = '0;
          closed_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q >= plim) begin
        cnt_d    = '0;
        closed_d = win_act;
        req_d    = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      closed_q <= 1'b1;
      req_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      closed_q <= closed_d;
      req_q    <= req_d;
    end
  end

  assign req_o = req_q;

  // R7 R3
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && per_valid_i) |=> !req_o);
  // R2
  req_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (cnt_q == '0));
  // R12
  req_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(tick_i || restart_i));
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdt_pkg::*;
#(
  parameter int unsigned MAX_CODE   = 10,
  parameter int unsigned BASE_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              unlock_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [CODE_W-1:0] fuse_per_i,
  input  logic              fuse_en_i,
  input  logic [CODE_W-1:0] fuse_wper_i,
  input  logic              fuse_wen_i,
  input  logic              fuse_lock_i,
  output logic              reset_req_o
);
  localparam int unsigned CNT_W = MAX_CODE + BASE_SHIFT + 1;

  logic [CODE_W-1:0] per, wper;
  logic              en, wen;
  logic              per_valid, wper_valid;
  logic [CNT_W-1:0]  per_cycles, wper_cycles;

  wdt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .unlock_i,
    .lock_i(fuse_lock_i),
    .fuse_per_i, .fuse_en_i, .fuse_wper_i, .fuse_wen_i,
    .rd_sel_i, .rd_data_o,
    .per_o(per), .en_o(en), .wper_o(wper), .wen_o(wen)
  );

  wdt_per_dec #(.MAX_CODE(MAX_CODE), .BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_per_dec (
    .code_i(per), .valid_o(per_valid), .cycles_o(per_cycles)
  );

  wdt_per_dec #(.MAX_CODE(MAX_CODE), .BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_win_dec (
    .code_i(wper), .valid_o(wper_valid), .cycles_o(wper_cycles)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i, .restart_i,
    .enable_i(en), .per_valid_i(per_valid), .per_cycles_i(per_cycles),
    .win_en_i(wen), .wper_valid_i(wper_valid), .wper_cycles_i(wper_cycles),
    .req_o(reset_req_o)
  );
endmodule

// File: tb/win_wdog_bench.sv
module win_wdog_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, restart_i = 1'b0, unlock_i = 1'b1;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [3:0] fuse_per_i = 4'd2, fuse_wper_i = 4'd5;
  logic       fuse_en_i = 1'b0, fuse_wen_i = 1'b1, fuse_lock_i = 1'b0;
  logic       reset_req_o;
  int errors = 0, checks = 0;

  always #4 clk_i = ~clk_i;

  win_wdog u_win_wdog (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd_check(input bit sel, input int exp, input string req);
    rd_sel_i = sel; #1;
    check(rd_data_o == 8'(exp), req, rd_data_o, exp);
  endtask

  // returns reset_req_o as seen one clock after the tick
  task automatic pulse_tick(output bit req);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; req = reset_req_o;
  endtask

  task automatic pulse_restart(output bit req);
    @(negedge clk_i); restart_i = 1'b1;
    @(negedge clk_i); restart_i = 1'b0; req = reset_req_o;
  endtask

  task automatic run_until_req(input int maxn, output int got);
    bit r;
    got = 0;
    for (int k = 1; k <= maxn; k++) begin
      pulse_tick(r);
      if (r) begin got = k; break; end
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int got;
    bit r;
    bit any;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R5 reset values from fuses
    rd_check(1'b0, 8'h08, "R1 ctrl reset");
    rd_check(1'b1, 8'h16, "R1 win reset");

    // R4 protection and change-enable gating
    unlock_i = 1'b0; wr(1'b0, 8'h07); unlock_i = 1'b1;
    rd_check(1'b0, 8'h08, "R4 locked-out write");
    wr(1'b0, 8'h06);
    rd_check(1'b0, 8'h08, "R4 write without change-enable");

    // R5 reserved bits read zero
    wr(1'b1, 8'hFF);
    rd_check(1'b1, 8'h3F, "R5 reserved bits");
    wr(1'b1, 8'h01);
    rd_check(1'b1, 8'h01, "R5 window fields");

    // R7 disabled watchdog
    any = 0;
    for (int k = 0; k < 40; k++) begin pulse_tick(r); any |= r; end
    pulse_restart(r); any |= r;
    check(!any, "R7 disabled no request", any, 0);

    // R2 R12 sweep every valid period code
    for (int c = 0; c <= 10; c++) begin
      wr(1'b0, 8'((c << 2) | 3));
      run_until_req((1 << (c + 3)) + 2, got);
      check(got == (1 << (c + 3)), "R2 timeout ticks", got, 1 << (c + 3));
      @(negedge clk_i);
      check(reset_req_o == 1'b0, "R12 one-clock request", reset_req_o, 0);
    end
    run_until_req(8200, got);
    check(got == 8192, "R2 counter restarts", got, 8192);

    // R3 reserved period codes
    for (int c = 11; c <= 15; c++) begin
      wr(1'b0, 8'((c << 2) | 3));
      run_until_req(100, got);
      pulse_restart(r);
      check(got == 0 && !r, "R3 reserved code silent", got, 0);
    end

    // R8 restart clears counter
    wr(1'b0, 8'h03);
    run_until_req(7, got);
    check(got == 0, "R8 no early request", got, 0);
    pulse_restart(r);
    check(!r, "R8 restart outside window", r, 0);
    run_until_req(10, got);
    check(got == 8, "R8 full period after restart", got, 8);

    // R6 lock
    wr(1'b1, 8'h05);
    rd_check(1'b1, 8'h05, "R6 unlocked write");
    fuse_lock_i = 1'b1;
    wr(1'b1, 8'h3F);
    rd_check(1'b1, 8'h07, "R6 locked window write");
    wr(1'b0, 8'h3D);
    rd_check(1'b0, 8'h01, "R6 locked ctrl write");
    fuse_lock_i = 1'b0;

    // R9 R10 window mode: closed 8 ticks, period 16 ticks
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h07);
    run_until_req(3, got);
    pulse_restart(r);
    check(r, "R9 early restart faults", r, 1);
    @(negedge clk_i);
    check(reset_req_o == 1'b0, "R12 fault pulse one clock", reset_req_o, 0);
    run_until_req(7, got);
    pulse_restart(r);
    check(r, "R9 restart at last closed tick", r, 1);
    run_until_req(8, got);
    check(got == 0, "R10 closed window no timeout", got, 0);
    pulse_restart(r);
    check(!r, "R10 open-window restart", r, 0);
    run_until_req(40, got);
    check(got == 24, "R10 closed plus open timeout", got, 24);

    // R11 reserved closed-window code
    wr(1'b1, 8'h3F);
    pulse_restart(r);
    check(!r, "R11 window inactive", r, 0);
    run_until_req(20, got);
    check(got == 16, "R11 plain timeout", got, 16);

    finish_run();
  end
endmodule